// File: doc/BRIEF.md
# Pseudo-random logic self-test engine

This block wraps a small combinational circuit with a self-test path. During normal operation the circuit receives the functional input word unchanged. When a test runs, the wrapper takes over the circuit inputs. It drives them with patterns from a maximal-length linear feedback shift register. The patterns first pass through an XOR phase-shift network, so that adjacent input bits are no longer shifted copies of one another in time.

The circuit responses come back into the wrapper on the `cut_resp` input. A multiple-input signature register folds them into one signature word, over a fixed number of patterns. When the last pattern has been applied, the controller compares the signature with a golden value supplied on an input port. It then reports done together with either pass or error.

A run can be launched in two ways. One is a start pulse. The other is automatic, on the first clock after reset is released, when the block is built with that option. Because the circuit sits outside the wrapper's port list, a fault can be injected on the response path by the surrounding logic or by a testbench.

Top module: `lbist_engine`

## Requirements
- R1: While `test_active` is low, `cut_in` equals `func_in` in every cycle.
- R2: While `test_active` is high, the block drives `cut_in` from an internal generator state L, passed through a phase-shift network.
  - L is loaded with SEED in the launch cycle. It then advances once per active cycle as L' = {L[N-2:0], parity(L & TAPS)}.
  - The phase-shift network computes `cut_in[i]` = L[i] ^ L[(i+3)%N] ^ L[(i+5)%N].
  - The first active cycle presents the pattern derived from SEED.
- R3: Within a run of 2^N-1 patterns, `cut_in` is never all-zero and no value repeats.
- R4: `test_active` rises on the clock edge at which a launch is accepted. It stays high for exactly PAT_COUNT cycles.
- R5: The signature register behaves as follows.
  - It is cleared at launch.
  - In each active cycle it updates as S' = {S[M-2:0], parity(S & MISR_TAPS)} ^ `cut_resp`.
  - Its value is visible on `signature`.
- R6: One cycle after the last pattern, the block compares `signature` with `golden_sig`. On the next cycle `done` rises, `pass` = (S == golden), and `error` is the inverse of `pass`.
- R7: `done`, `pass` and `error` hold their values until the next start. A start accepted in the done state clears all three and begins a new run.
- R8: A start pulse that arrives while a run is in progress is ignored. The run length and the final signature do not change.
- R9: With AUTO_START = 1, a run begins on the first clock edge after reset is released, with no start pulse.
- R10: While reset is asserted, `test_active`, `done`, `pass` and `error` are low, and `cut_in` equals `func_in`.
- R11: A response fault that changes the final signature away from `golden_sig` produces `error` = 1 and `pass` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Pulse that launches a run when the block is idle or done |
| func_in | input | N_IN | Functional input word for the circuit |
| cut_in | output | N_IN | Input word applied to the circuit under test |
| cut_resp | input | N_OUT | Response word from the circuit under test |
| golden_sig | input | N_OUT | Expected fault-free signature |
| signature | output | N_OUT | Current signature register contents |
| test_active | output | 1 | High while patterns are being applied |
| done | output | 1 | Run finished and verdict valid |
| pass | output | 1 | Signature matched the golden value |
| error | output | 1 | Signature did not match the golden value |

## Verification
The bench builds the block with an 8-bit generator, an 8-bit signature register, PAT_COUNT = 255 and AUTO_START = 1. Because PAT_COUNT equals the full generator period, one run walks every non-zero state. This lets the bench prove that no pattern is zero and none repeats. It also lets the bench check the phase shifter against a model on all 255 patterns. Since reset launches a run, the start-up path is exercised as well. Stuck-at faults on single response bits, and a corrupted golden word, are then used to show the verdict following the computed signature.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CMP  = 2'd2,
    ST_DONE = 2'd3
  } lbist_state_e;

endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb = ^(state_q & TAPS);
    state_d = state_q;
    if (load) begin
      state_d = SEED;
    end else if (step) begin
      state_d = {state_q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (load || step) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R3

endmodule

// File: rtl/lbist_phase_shift.sv
module lbist_phase_shift #(
  parameter int W     = 8,
  parameter int OFS_A = 3,
  parameter int OFS_B = 5
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);

  for (genvar i = 0; i < W; i++) begin : g_tap
    localparam int IA = (i + OFS_A) % W;
    localparam int IB = (i + OFS_B) % W;
    assign dst[i] = src[i] ^ src[IA] ^ src[IB];
  end

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] resp,
  output logic [W-1:0] sig
);

  logic [W-1:0] sig_q;
  logic [W-1:0] sig_d;

  always_comb begin
    sig_d = sig_q;
    if (clr) begin
      sig_d = '0;
    end else if (en) begin
      sig_d = {sig_q[W-2:0], ^(sig_q & TAPS)} ^ resp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (clr || en) begin
      sig_q <= sig_d;
    end
  end

  assign sig = sig_q;

  AST_MISR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(sig_q)); // R6

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int PAT_COUNT  = 255,
  parameter bit AUTO_START = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sig_match,
  output logic launch,
  output logic run_en,
  output logic done,
  output logic pass,
  output logic error
);

  localparam int CNT_W = (PAT_COUNT > 1) ? $clog2(PAT_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_COUNT - 1);

  lbist_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             boot_q, boot_d;
  logic             pass_q, pass_d;
  logic             err_q, err_d;
  logic             last_pat;

  assign last_pat = (cnt_q == LAST);
  assign launch   = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && (start || boot_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    boot_d  = boot_q;
    pass_d  = pass_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (launch) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          boot_d  = 1'b0;
          pass_d  = 1'b0;
          err_d   = 1'b0;
        end
      end
      ST_RUN: begin
        if (last_pat) begin
          state_d = ST_CMP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CMP: begin
        state_d = ST_DONE;
        pass_d  = sig_match;
        err_d   = !sig_match;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      boot_q  <= AUTO_START;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      boot_q  <= boot_d;
      pass_q  <= pass_d;
      err_q   <= err_d;
    end
  end

  assign run_en = (state_q == ST_RUN);
  assign done   = (state_q == ST_DONE);
  assign pass   = pass_q;
  assign error  = err_q;

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ error)); // R6

  AST_RUN_TO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && last_pat) |=> (state_q == ST_CMP)); // R4

  AST_HOLD_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(error))); // R7

  AST_RUN_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !last_pat) |=> (run_en && (cnt_q == $past(cnt_q) + 1'b1))); // R8

endmodule

// File: rtl/lbist_engine.sv
module lbist_engine #(
  parameter int               N_IN       = 8,
  parameter int               N_OUT      = 8,
  parameter int               PAT_COUNT  = 255,
  parameter bit               AUTO_START = 1'b1,
  parameter logic [N_IN-1:0]  TAPS       = 8'hB8,
  parameter logic [N_IN-1:0]  SEED       = 8'h01,
  parameter logic [N_OUT-1:0] MISR_TAPS  = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_IN-1:0]  func_in,
  output logic [N_IN-1:0]  cut_in,
  input  logic [N_OUT-1:0] cut_resp,
  input  logic [N_OUT-1:0] golden_sig,
  output logic [N_OUT-1:0] signature,
  output logic             test_active,
  output logic             done,
  output logic             pass,
  output logic             error
);

  logic            launch;
  logic            run_en;
  logic            sig_match;
  logic [N_IN-1:0] gen_state;
  logic [N_IN-1:0] shifted;

  lbist_ctrl #(
    .PAT_COUNT (PAT_COUNT),
    .AUTO_START(AUTO_START)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sig_match(sig_match),
    .launch   (launch),
    .run_en   (run_en),
    .done     (done),
    .pass     (pass),
    .error    (error)
  );

  lbist_lfsr #(
    .W   (N_IN),
    .TAPS(TAPS),
    .SEED(SEED)
  ) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (launch),
    .step (run_en),
    .state(gen_state)
  );

  lbist_phase_shift #(
    .W    (N_IN),
    .OFS_A(3),
    .OFS_B(5)
  ) u_pshift (
    .src(gen_state),
    .dst(shifted)
  );

  lbist_misr #(
    .W   (N_OUT),
    .TAPS(MISR_TAPS)
  ) u_misr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (launch),
    .en   (run_en),
    .resp (cut_resp),
    .sig  (signature)
  );

  assign sig_match   = (signature == golden_sig);
  assign test_active = run_en;
  assign cut_in      = run_en ? shifted : func_in;

  AST_PATTERN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |-> (cut_in != '0)); // R3

  AST_MISR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (signature == '0)); // R5

endmodule

// File: tb/test_lbist_engine.sv
module test_lbist_engine;

  localparam int N        = 8;
  localparam int PATS     = 255;
  localparam logic [7:0] TAPS  = 8'hB8;
  localparam logic [7:0] SEED  = 8'h01;
  localparam logic [7:0] MTAPS = 8'hB8;
  localparam int NVAL     = 2 ** N;

  // vector: {fault_en, fault_bit[2:0], fault_val, golden_flip[7:0]}
  localparam int NVEC = 5;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 1'b0, 8'h00},
    {1'b1, 3'd2, 1'b0, 8'h00},
    {1'b1, 3'd7, 1'b1, 8'h00},
    {1'b0, 3'd0, 1'b0, 8'h01},
    {1'b1, 3'd5, 1'b1, 8'h00}
  };

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [7:0]   func_in;
  logic [7:0]   cut_in;
  logic [7:0]   cut_resp;
  logic [7:0]   golden_sig;
  logic [7:0]   signature;
  logic         test_active, done, pass, error;

  logic         f_en;
  logic [2:0]   f_bit;
  logic         f_val;

  int n_checks;
  int n_fail;

  lbist_engine #(
    .N_IN(8), .N_OUT(8), .PAT_COUNT(PATS), .AUTO_START(1'b1),
    .TAPS(TAPS), .SEED(SEED), .MISR_TAPS(MTAPS)
  ) i_lbist_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .func_in(func_in),
    .cut_in(cut_in), .cut_resp(cut_resp), .golden_sig(golden_sig),
    .signature(signature), .test_active(test_active), .done(done),
    .pass(pass), .error(error)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] gen_step(input logic [7:0] l);
    return {l[6:0], ^(l & TAPS)};
  endfunction

  function automatic logic [7:0] pshift(input logic [7:0] l);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = l[i] ^ l[(i + 3) % 8] ^ l[(i + 5) % 8];
    return o;
  endfunction

  function automatic logic [7:0] cut_model(input logic [7:0] x, input logic fe,
                                           input logic [2:0] fb, input logic fv);
    logic [7:0] r;
    r = (x + {x[3:0], x[7:4]}) ^ {x[0], x[7:1]} ^ (x & {x[6:0], x[7]});
    if (fe) r[fb] = fv;
    return r;
  endfunction

  function automatic logic [7:0] ref_sig(input logic fe, input logic [2:0] fb,
                                         input logic fv);
    logic [7:0] l = SEED;
    logic [7:0] s = '0;
    for (int k = 0; k < PATS; k++) begin
      s = {s[6:0], ^(s & MTAPS)} ^ cut_model(pshift(l), fe, fb, fv);
      l = gen_step(l);
    end
    return s;
  endfunction

  always_comb cut_resp = cut_model(cut_in, f_en, f_bit, f_val);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // pattern monitor
  logic [7:0]      mon_l;
  logic [NVAL-1:0] seen;
  int              mon_cnt;
  logic            mon_act;

  initial mon_act = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (test_active) begin
        if (!mon_act) begin
          mon_l   = SEED;
          seen    = '0;
          mon_cnt = 0;
        end
        check(cut_in == pshift(mon_l), "R2", cut_in, pshift(mon_l));
        check(cut_in != 8'h00 && !seen[cut_in], "R3", cut_in, 1);
        seen[cut_in] = 1'b1;
        mon_l = gen_step(mon_l);
        mon_cnt++;
      end else begin
        check(cut_in == func_in, "R1", cut_in, func_in);
        if (mon_act) check(mon_cnt == PATS, "R4", mon_cnt, PATS);
      end
      mon_act = test_active;
    end
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
    end
    check(ok, "R6", 0, 1);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] clean_sig, exp_sig, gold;
    logic       exp_pass;
    bit         ok;
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    func_in  = 8'h5A;
    f_en = 1'b0; f_bit = 3'd0; f_val = 1'b0;
    clean_sig  = ref_sig(1'b0, 3'd0, 1'b0);
    golden_sig = clean_sig;

    // R10 reset state
    repeat (3) @(negedge clk);
    check(!test_active && !done && !pass && !error, "R10",
          {test_active, done, pass, error}, 0);
    check(cut_in == func_in, "R10", cut_in, func_in);
    rst_n = 1'b1;

    // R9 launch on reset release
    @(negedge clk);
    check(test_active == 1'b1, "R9", test_active, 1);
    check(signature == 8'h00, "R5", signature, 0);
    wait_done(ok);
    check(signature == clean_sig, "R5", signature, clean_sig);
    check(pass && !error, "R6", {pass, error}, 2'b10);

    // R7 hold while done
    func_in = 8'hC3;
    repeat (6) @(negedge clk);
    check(done && pass && !error, "R7", {done, pass, error}, 3'b110);

    // table of fault / golden scenarios
    for (int v = 0; v < NVEC; v++) begin
      f_en  = VEC[v][12];
      f_bit = VEC[v][11:9];
      f_val = VEC[v][8];
      gold  = clean_sig ^ VEC[v][7:0];
      golden_sig = gold;
      exp_sig  = ref_sig(f_en, f_bit, f_val);
      exp_pass = (exp_sig == gold);
      func_in  = 8'(v * 37 + 11);
      pulse_start();
      check(test_active && !done && !pass && !error, "R7",
            {test_active, done, pass, error}, 4'b1000);
      wait_done(ok);
      check(signature == exp_sig, "R5", signature, exp_sig);
      check(pass == exp_pass && error == !exp_pass, "R11",
            {pass, error}, {exp_pass, !exp_pass});
      repeat (4) @(negedge clk);
      check(done && pass == exp_pass && error == !exp_pass, "R7",
            {done, pass, error}, {1'b1, exp_pass, !exp_pass});
    end

    // R8 start during run ignored
    f_en = 1'b0;
    golden_sig = clean_sig;
    pulse_start();
    repeat (50) @(negedge clk);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_done(ok);
    check(signature == clean_sig, "R8", signature, clean_sig);
    check(pass && !error, "R8", {pass, error}, 2'b10);
    repeat (3) @(negedge clk);
    check(!test_active && done, "R8", {test_active, done}, 2'b01);

    summary();
  end

endmodule